// File: doc/BRIEF.md
# Opmode-Steered Multiply-Add Slice

This block is one arithmetic slice for a signal-processing column. It holds a signed 18 by 18 multiplier, a 48-bit adder/subtractor and a 48-bit result register P. A 7-bit operation word chooses the three adder operands each cycle. With it the same hardware works as a plain multiplier, a multiply-accumulator, a link in an adder cascade, a wide adder, a loadable counter or one step of a wide shift.

The operation word splits into three fields. Bits [1:0] drive the first operand mux (named X). Bits [3:2] drive the second operand mux (named Y). Bits [6:4] drive the third operand mux (named Z), which is the minuend. The result is Z plus the sum X + Y + carry-in. When the subtract control is set, the result is Z minus that sum. Slices are chained by wiring one slice's `cas_out` to the next slice's `cas_in`. The word may differ on every clock, so one slice can be shared by several operations in time-division.

Top module: `mac_slice`

## Requirements
- R1: A synchronous reset clears P, the illegal flag and the input stage. On the first enabled edge after reset, the slice therefore computes with operation word 0000000, all operands zero and carry-in zero, and P stays 0.
- R2: The loaded result is Z + (X + Y + cin) when `sub` is 0 and Z - (X + Y + cin) when `sub` is 1. All arithmetic is modulo 2^48. With X and Y both on the multiplier, X + Y equals the signed product a*b, sign-extended to 48 bits.
- R3: X field, bits [1:0]: 00 gives zero, 01 gives a multiplier partial, 10 gives P, and 11 gives {a,b}. In the last case a lands in bits 35:18, b lands in bits 17:0, and bits 47:36 are zero.
- R4: Y field, bits [3:2]: 00 gives zero, 01 gives the other multiplier partial, and 11 gives c.
- R5: Z field, bits [6:4]: 000 gives zero, 001 gives `cas_in`, 010 gives P and 011 gives c. 101 gives `cas_in` shifted arithmetically right by 17, and 110 gives P shifted arithmetically right by 17.
- R6: Some operation words are illegal: X field 01 without Y field 01, Y field 01 without X field 01, Y field 10, and Z field 100 or 111. An illegal word loads P with 0 and sets `op_bad`. Any legal word clears `op_bad`.
- R7: A new operation word may be applied on every clock. Each word acts on its own operands with no idle cycle between words.
- R8: Operands, `sub`, `cin` and the operation word presented before clock edge k affect P right after edge k+1, and not after edge k. `cas_in` and `p_en` are used at edge k+1.
- R9: When `p_en` is low at an edge, P and `op_bad` keep their values.
- R10: `cas_out` always equals P.
- R11: Word 0100101 accumulates: P becomes the old P plus a*b (plus cin), edge after edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p_en | input | 1 | Enable of the result register |
| a | input | 18 | Signed multiplier operand, upper half of {a,b} |
| b | input | 18 | Signed multiplier operand, lower half of {a,b} |
| c | input | 48 | Wide operand |
| cas_in | input | 48 | Cascade input from the previous slice |
| opmode | input | 7 | Operation word: Z[6:4], Y[3:2], X[1:0] |
| sub | input | 1 | Subtract the X+Y+cin sum from Z |
| cin | input | 1 | Carry-in |
| p | output | 48 | Result register |
| cas_out | output | 48 | Cascade output, equal to P |
| op_bad | output | 1 | Set when P was loaded under an illegal operation word |

## Verification
Two things can land in the same cycle. One is a change of operation word while the previous word is still in the pipeline. The other is a P feedback term (Z or X on P) that reads a P value which the previous word has just written. The bench walks every one of the 128 words back to back, with both subtract settings and three operand patterns, and gates `p_en` on some edges. A cycle-true arithmetic model compares P, `cas_out` and `op_bad` on every cycle. A wrong stage alignment or a stale feedback value shows up as a mismatch on the word that follows.

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int AW = 18,
  parameter int BW = 18,
  parameter int PW = 48,
  parameter int SH = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_en,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [PW-1:0] c,
  input  logic [PW-1:0] cas_in,
  input  logic [6:0]    opmode,
  input  logic          sub,
  input  logic          cin,
  output logic [PW-1:0] p,
  output logic [PW-1:0] cas_out,
  output logic          op_bad
);
  localparam int MW = AW + BW;
  localparam int BL = BW / 2;
  localparam int BH = BW - BL;

  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic [PW-1:0] c_q;
  logic [6:0]    op_q;
  logic          sub_q, cin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; c_q <= '0; op_q <= '0; sub_q <= 1'b0; cin_q <= 1'b0;
    end else begin
      a_q <= a; b_q <= b; c_q <= c; op_q <= opmode; sub_q <= sub; cin_q <= cin;
    end
  end

  logic [PW-1:0] a_x, blo_x, bhi_x, pp_lo, pp_hi;
  assign a_x   = {{(PW-AW){a_q[AW-1]}}, a_q};
  assign blo_x = {{(PW-BL){1'b0}}, b_q[BL-1:0]};
  assign bhi_x = {{(PW-BH){b_q[BW-1]}}, b_q[BW-1:BL]};
  assign pp_lo = a_x * blo_x;
  assign pp_hi = (a_x * bhi_x) << BL;

  logic [PW-1:0] xv, yv, zv, sum, nxt;

  always_comb begin
    case (op_q[1:0])
      2'b01:   xv = pp_lo;
      2'b10:   xv = p;
      2'b11:   xv = {{(PW-MW){1'b0}}, a_q, b_q};
      default: xv = '0;
    endcase
    case (op_q[3:2])
      2'b01:   yv = pp_hi;
      2'b11:   yv = c_q;
      default: yv = '0;
    endcase
    case (op_q[6:4])
      3'b001:  zv = cas_in;
      3'b010:  zv = p;
      3'b011:  zv = c_q;
      3'b101:  zv = PW'($signed(cas_in) >>> SH);
      3'b110:  zv = PW'($signed(p) >>> SH);
      default: zv = '0;
    endcase
  end

  logic x_mul, y_mul, bad;
  assign x_mul = (op_q[1:0] == 2'b01);
  assign y_mul = (op_q[3:2] == 2'b01);
  assign bad   = (x_mul != y_mul) || (op_q[3:2] == 2'b10) ||
                 (op_q[6:4] == 3'b100) || (op_q[6:4] == 3'b111);

  assign sum = xv + yv + {{(PW-1){1'b0}}, cin_q};
  assign nxt = sub_q ? (zv - sum) : (zv + sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      p      <= '0;
      op_bad <= 1'b0;
    end else if (p_en) begin
      p      <= bad ? '0 : nxt;
      op_bad <= bad;
    end
  end

  assign cas_out = p;
endmodule

module mac_slice_chk #(
  parameter int AW = 18,
  parameter int BW = 18,
  parameter int PW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          p_en,
  input logic [AW-1:0] a,
  input logic [BW-1:0] b,
  input logic [6:0]    opmode,
  input logic          sub,
  input logic          cin,
  input logic [PW-1:0] p,
  input logic [PW-1:0] cas_out,
  input logic          op_bad
);
  logic [1:0]    warm;
  logic [AW-1:0] a_d1, a_d2;
  logic [BW-1:0] b_d1, b_d2;
  logic [6:0]    op_d1, op_d2;
  logic          s_d1, s_d2, ci_d1, ci_d2, ce_d1;
  logic [PW-1:0] mul_exp;

  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
    a_d1 <= a; a_d2 <= a_d1;
    b_d1 <= b; b_d2 <= b_d1;
    op_d1 <= opmode; op_d2 <= op_d1;
    s_d1 <= sub; s_d2 <= s_d1;
    ci_d1 <= cin; ci_d2 <= ci_d1;
    ce_d1 <= p_en;
  end

  assign mul_exp = {{(PW-AW){a_d2[AW-1]}}, a_d2} * {{(PW-BW){b_d2[BW-1]}}, b_d2};

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (p == '0 && !op_bad));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst) !p_en |=> $stable(p) && $stable(op_bad));
  // R10
  cascade_chk: assert property (@(posedge clk) disable iff (rst) cas_out == p);
  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst) op_bad |-> p == '0);
  // R2
  multiply_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && op_d2 == 7'b0000101 && !s_d2 && !ci_d2 && ce_d1) |-> (p == mul_exp && !op_bad));
endmodule

bind mac_slice mac_slice_chk #(.AW(AW), .BW(BW), .PW(PW)) u_chk (.*);

// File: tb/test_mac_slice.sv
module test_mac_slice;
  logic        clk = 1'b0;
  logic        rst, p_en, sub, cin;
  logic [17:0] a, b;
  logic [47:0] c, cas_in;
  logic [6:0]  opmode;
  logic [47:0] p, cas_out;
  logic        op_bad;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mac_slice i_mac_slice (.clk(clk), .rst(rst), .p_en(p_en), .a(a), .b(b), .c(c),
    .cas_in(cas_in), .opmode(opmode), .sub(sub), .cin(cin), .p(p), .cas_out(cas_out),
    .op_bad(op_bad));

  function automatic logic [48:0] ref_next(input logic [6:0] op, input logic [17:0] ra, rb,
    input logic [47:0] rc, rpc, rp, input logic rs, rci);
    logic [47:0] prod, xv, yv, zv, s;
    logic bad;
    prod = {{30{ra[17]}}, ra} * {{30{rb[17]}}, rb};
    bad = ((op[1:0] == 2'b01) != (op[3:2] == 2'b01)) || op[3:2] == 2'b10 ||
          op[6:4] == 3'b100 || op[6:4] == 3'b111;
    case (op[1:0]) 2'b01: xv = prod; 2'b10: xv = rp; 2'b11: xv = {12'b0, ra, rb}; default: xv = '0; endcase
    yv = (op[3:2] == 2'b11) ? rc : 48'd0;
    case (op[6:4])
      3'b001: zv = rpc; 3'b010: zv = rp; 3'b011: zv = rc;
      3'b101: zv = 48'($signed(rpc) >>> 17); 3'b110: zv = 48'($signed(rp) >>> 17);
      default: zv = '0;
    endcase
    s = xv + yv + {47'd0, rci};
    return {bad, bad ? 48'd0 : (rs ? zv - s : zv + s)};
  endfunction

  // cycle model: input stage, then result register
  logic [17:0] m_a, m_b; logic [47:0] m_c, e_p; logic [6:0] m_op, e_op;
  logic m_s, m_ci, e_bad, e_ce;
  always @(posedge clk) begin
    if (rst) begin
      m_a <= 0; m_b <= 0; m_c <= 0; m_op <= 0; m_s <= 0; m_ci <= 0;
      e_p <= 0; e_bad <= 0; e_op <= 0; e_ce <= 1;
    end else begin
      m_a <= a; m_b <= b; m_c <= c; m_op <= opmode; m_s <= sub; m_ci <= cin;
      e_ce <= p_en;
      if (p_en) begin
        {e_bad, e_p} <= ref_next(m_op, m_a, m_b, m_c, cas_in, e_p, m_s, m_ci);
        e_op <= m_op;
      end
    end
  end

  task automatic check(input string tag, input logic [47:0] exp_p, input logic exp_bad);
    n_chk++;
    if (p !== exp_p || op_bad !== exp_bad) begin
      n_bad++;
      $display("FAIL %s: p=%h bad=%b expected p=%h bad=%b", tag, p, op_bad, exp_p, exp_bad);
    end
    n_chk++;
    if (cas_out !== p) begin
      n_bad++;
      $display("FAIL R10: cas_out=%h expected %h", cas_out, p);
    end
  endtask

  function automatic string tag_of(input logic [6:0] op, input logic ce);
    logic bad;
    bad = ((op[1:0] == 2'b01) != (op[3:2] == 2'b01)) || op[3:2] == 2'b10 ||
          op[6:4] == 3'b100 || op[6:4] == 3'b111;
    if (!ce) return "R9";
    if (bad) return "R6";
    if (op == 7'b0100101) return "R11";
    if (op[1:0] == 2'b01) return "R2";
    if (op[6:4] == 3'b101 || op[6:4] == 3'b110) return "R5";
    if (op[3:2] == 2'b11) return "R4";
    return "R3";
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    rst = 1; p_en = 1; sub = 0; cin = 0; a = 0; b = 0; c = 0; cas_in = 0; opmode = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", 48'd0, 1'b0);

    // R8: C load via Y field, then hold via Z=P
    opmode = 7'b0001100; c = 48'h1234_5678; cin = 0;
    @(negedge clk);
    opmode = 7'b0100000; c = 0;
    check("R8", 48'd0, 1'b0);
    @(negedge clk);
    check("R8", 48'h1234_5678, 1'b0);

    // R11: accumulate a*b several times, starting from the loaded value
    opmode = 7'b0100101; a = 18'h3FFFD; b = 18'd1000; // -3 * 1000
    repeat (2) @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      check("R11", 48'h1234_5678 - 48'(3000 * k), 1'b0);
      @(negedge clk);
    end

    // R1: reset clears the input stage too
    opmode = 7'b0001100; c = 48'd77;
    @(negedge clk);
    rst = 1; opmode = 7'b0000000; c = 0;
    @(negedge clk);
    rst = 0;
    check("R1", 48'd0, 1'b0);
    @(negedge clk);
    check("R1", 48'd0, 1'b0);

    // R7 sweep: every word back to back, both subtract settings, three patterns
    for (int set = 0; set < 3; set++) begin
      for (int s = 0; s < 2; s++) begin
        for (int op = 0; op < 128; op++) begin
          opmode = 7'(op);
          sub    = s[0];
          cin    = op[0] ^ set[0];
          a      = 18'(op * 2731 + set * 40503 + s * 777);
          b      = 18'(op * 977 + set * 123457 + 5);
          c      = 48'(op * 64'h1_0003_F1A7 + set * 64'h7FFF_0000_1234);
          cas_in = 48'(op * 64'h3_00A1_0513 ^ (set * 64'h8000_0000_0001));
          p_en   = (set == 2) ? ((op % 5) != 0) : 1'b1;
          @(negedge clk);
          check(tag_of(e_op, e_ce), e_p, e_bad);
        end
      end
    end
    p_en = 1;
    repeat (2) @(negedge clk);
    check("R7", e_p, e_bad);
    summary();
  end
endmodule